// File: doc/BRIEF.md
# Load-Branch Correlation Queue

This block links the dynamic instances of one chosen load to later dynamic instances of one chosen branch, so that the branch can be predicted from a load address. Each time the load is dispatched it takes a slot in a circular queue and receives a pointer, which the reorder buffer carries with the instruction. When the load computes its address, the address goes into its slot and a lookup request goes out to an external correlation table. The table writes its answer back into the slot.

When the branch is fetched it selects the slot a programmable number of load instances back from the newest one. Distance 0 selects the newest load, and distance k selects the load k instances earlier. If the table answer is already in the slot, the branch uses it instead of the primary prediction. If the answer is not there yet, the slot remembers the primary prediction. A later answer that disagrees with it raises an override. When the branch retires, the queue sends the stored address and the real outcome out for training. Slots are released in order when their loads retire. A flush puts the tail back to a checkpoint value. One instance serves one load/branch pair.

Top module: `ld_br_corr_queue`

## Requirements
- R1: After reset the queue is empty. `alloc_ptr` is 0, `alloc_ok` is 1, `tail_ckpt` is 0, and no branch gets a hit.
- R2: Each accepted load allocation returns the next slot index in sequence, modulo DEPTH. `tail_ckpt` counts allocations modulo 2*DEPTH. With DEPTH slots live, `alloc_ok` is 0 and the allocation is dropped: the pointer does not advance.
- R3: An address write to a live slot raises `lookup_valid` in the same cycle, carrying that address and slot. A write to a slot that is not live raises nothing.
- R4: A branch with distance d selects slot (tail-1-d) mod DEPTH. It hits only when more than d slots are live.
- R5: If the selected slot already holds a table answer, `br_use` is 1 and `br_pred` is that answer. Otherwise `br_use` is 0.
- R6: A hit without an answer records `br_primary` and marks the slot waiting. A later table answer for that slot raises `ovr_valid` in the same cycle, with `ovr_taken` equal to the answer, only when the answer differs from the recorded primary.
- R7: A branch retire naming a live slot whose address is present raises `upd_valid` with the stored address and `retire_taken`. Otherwise `upd_valid` is 0.
- R8: A load retire frees the oldest slot. Freed slots give no hit, no lookup and no update, and their space can be allocated again.
- R9: A flush sets the tail to `flush_tail`. Slots beyond the new tail are dead, and the next allocation reuses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Load dispatched, request a slot |
| alloc_ok | output | 1 | A slot is free; request accepted |
| alloc_ptr | output | PW | Slot index granted to the load |
| tail_ckpt | output | PW+1 | Current tail, for checkpointing |
| free_valid | input | 1 | Oldest load retired; release head slot |
| flush_valid | input | 1 | Restore the tail |
| flush_tail | input | PW+1 | Checkpointed tail value |
| agen_valid | input | 1 | Load address generated |
| agen_ptr | input | PW | Slot of that load |
| agen_addr | input | AW | Load address bits |
| lookup_valid | output | 1 | Table lookup request |
| lookup_ptr | output | PW | Slot for the lookup |
| lookup_addr | output | AW | Address to look up |
| pred_valid | input | 1 | Table answer arrives |
| pred_ptr | input | PW | Slot the answer belongs to |
| pred_taken | input | 1 | Answer direction |
| br_valid | input | 1 | Branch fetched |
| br_dist | input | DW | Correlation distance |
| br_primary | input | 1 | Primary predictor direction |
| br_hit | output | 1 | A live slot is linked |
| br_ptr | output | PW | Linked slot index |
| br_use | output | 1 | Substitute the primary prediction |
| br_pred | output | 1 | Substituted direction |
| ovr_valid | output | 1 | Late answer disagrees; override |
| ovr_ptr | output | PW | Slot of the override |
| ovr_taken | output | 1 | Override direction |
| retire_valid | input | 1 | Branch retired |
| retire_ptr | input | PW | Slot linked to the branch |
| retire_taken | input | 1 | Real outcome |
| upd_valid | output | 1 | Training update |
| upd_addr | output | AW | Stored load address |
| upd_taken | output | 1 | Outcome for training |

## Verification
The bench builds the queue with DEPTH=8, AW=12 and DW=3. A depth of eight makes the full queue, the dropped allocation and wrap-around of slot indices reachable in a few dozen cycles. It also makes the largest distance, 7, land exactly on the oldest slot of a full queue. The default depth of 64 differs only in width, and the assertions cover it.

// File: rtl/ld_br_corr_queue.sv
module ld_br_corr_queue #(
  parameter int DEPTH = 64,
  parameter int AW    = 12,
  parameter int DW    = 3,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ok,
  output logic [PW-1:0] alloc_ptr,
  output logic [PW:0]   tail_ckpt,
  input  logic          free_valid,
  input  logic          flush_valid,
  input  logic [PW:0]   flush_tail,
  input  logic          agen_valid,
  input  logic [PW-1:0] agen_ptr,
  input  logic [AW-1:0] agen_addr,
  output logic          lookup_valid,
  output logic [PW-1:0] lookup_ptr,
  output logic [AW-1:0] lookup_addr,
  input  logic          pred_valid,
  input  logic [PW-1:0] pred_ptr,
  input  logic          pred_taken,
  input  logic          br_valid,
  input  logic [DW-1:0] br_dist,
  input  logic          br_primary,
  output logic          br_hit,
  output logic [PW-1:0] br_ptr,
  output logic          br_use,
  output logic          br_pred,
  output logic          ovr_valid,
  output logic [PW-1:0] ovr_ptr,
  output logic          ovr_taken,
  input  logic          retire_valid,
  input  logic [PW-1:0] retire_ptr,
  input  logic          retire_taken,
  output logic          upd_valid,
  output logic [AW-1:0] upd_addr,
  output logic          upd_taken
);

  logic [PW:0]      head_q, tail_q, cnt;
  logic [DEPTH-1:0] pav_q, aav_q, pval_q, wt_q, prim_q;
  logic [AW-1:0]    addr_q [DEPTH];
  logic             alloc_fire, free_fire, pred_ok;

  function automatic logic live(input logic [PW-1:0] idx);
    logic [PW-1:0] off;
    off = idx - head_q[PW-1:0];
    return {1'b0, off} < cnt;
  endfunction

  assign cnt        = tail_q - head_q;
  assign alloc_ok   = cnt != (PW+1)'(DEPTH);
  assign alloc_ptr  = tail_q[PW-1:0];
  assign tail_ckpt  = tail_q;
  assign alloc_fire = alloc_valid && alloc_ok && !flush_valid;
  assign free_fire  = free_valid && cnt != '0;

  assign lookup_valid = agen_valid && live(agen_ptr);
  assign lookup_ptr   = agen_ptr;
  assign lookup_addr  = agen_addr;

  assign br_ptr  = tail_q[PW-1:0] - PW'(br_dist) - PW'(1);
  assign br_hit  = br_valid && (int'(br_dist) < int'(cnt));
  assign br_use  = br_hit && pav_q[br_ptr];
  assign br_pred = br_use && pval_q[br_ptr];

  assign pred_ok   = pred_valid && live(pred_ptr);
  assign ovr_valid = pred_ok && wt_q[pred_ptr] && (pred_taken != prim_q[pred_ptr]);
  assign ovr_ptr   = pred_ptr;
  assign ovr_taken = pred_taken;

  assign upd_valid = retire_valid && live(retire_ptr) && aav_q[retire_ptr];
  assign upd_addr  = addr_q[retire_ptr];
  assign upd_taken = retire_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      pav_q  <= '0;
      aav_q  <= '0;
      pval_q <= '0;
      wt_q   <= '0;
      prim_q <= '0;
    end else begin
      if (flush_valid)     tail_q <= flush_tail;
      else if (alloc_fire) tail_q <= tail_q + 1'b1;
      if (free_fire)       head_q <= head_q + 1'b1;
      if (alloc_fire) begin
        pav_q[alloc_ptr] <= 1'b0;
        aav_q[alloc_ptr] <= 1'b0;
        wt_q[alloc_ptr]  <= 1'b0;
      end
      if (lookup_valid) aav_q[agen_ptr] <= 1'b1;
      if (br_hit && !br_use) begin
        wt_q[br_ptr]   <= 1'b1;
        prim_q[br_ptr] <= br_primary;
      end
      if (pred_ok) begin
        pav_q[pred_ptr]  <= 1'b1;
        pval_q[pred_ptr] <= pred_taken;
        wt_q[pred_ptr]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    if (lookup_valid) addr_q[agen_ptr] <= agen_addr;

endmodule

// File: rtl/ld_br_corr_queue_chk.sv
module ld_br_corr_queue_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 3,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW:0]   cnt,
  input logic          alloc_valid,
  input logic          alloc_ok,
  input logic [PW-1:0] alloc_ptr,
  input logic          flush_valid,
  input logic [PW:0]   flush_tail,
  input logic [PW:0]   tail_ckpt,
  input logic [DW-1:0] br_dist,
  input logic          br_hit,
  input logic          br_use,
  input logic          pred_valid,
  input logic          ovr_valid,
  input logic          retire_valid,
  input logic          upd_valid
);

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ok && !flush_valid |=> alloc_ptr == PW'($past(alloc_ptr) + 1'b1));

  p_drop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_ok && !flush_valid |=> $stable(alloc_ptr));

  p_hit_dist_r4: assert property (@(posedge clk) disable iff (!rst_n)
    br_hit |-> int'(br_dist) < int'(cnt));

  p_use_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    br_use |-> br_hit);

  p_ovr_pred_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_valid |-> pred_valid);

  p_upd_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> retire_valid);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  p_flush_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> tail_ckpt == $past(flush_tail));

endmodule

bind ld_br_corr_queue ld_br_corr_queue_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .alloc_valid(alloc_valid),
  .alloc_ok(alloc_ok), .alloc_ptr(alloc_ptr), .flush_valid(flush_valid),
  .flush_tail(flush_tail), .tail_ckpt(tail_ckpt), .br_dist(br_dist),
  .br_hit(br_hit), .br_use(br_use), .pred_valid(pred_valid),
  .ovr_valid(ovr_valid), .retire_valid(retire_valid), .upd_valid(upd_valid)
);

// File: tb/test_ld_br_corr_queue.sv
`timescale 1ns/1ps
module test_ld_br_corr_queue;
  localparam int DEPTH = 8;
  localparam int AW = 12;
  localparam int DW = 3;
  localparam int PW = 3;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, free_valid = 0, flush_valid = 0;
  logic [PW:0] flush_tail = '0;
  logic agen_valid = 0; logic [PW-1:0] agen_ptr = '0; logic [AW-1:0] agen_addr = '0;
  logic pred_valid = 0; logic [PW-1:0] pred_ptr = '0; logic pred_taken = 0;
  logic br_valid = 0; logic [DW-1:0] br_dist = '0; logic br_primary = 0;
  logic retire_valid = 0; logic [PW-1:0] retire_ptr = '0; logic retire_taken = 0;
  logic alloc_ok, lookup_valid, br_hit, br_use, br_pred, ovr_valid, ovr_taken, upd_valid, upd_taken;
  logic [PW-1:0] alloc_ptr, lookup_ptr, br_ptr, ovr_ptr;
  logic [PW:0] tail_ckpt;
  logic [AW-1:0] lookup_addr, upd_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ld_br_corr_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_ld_br_corr_queue (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; free_valid = 0; flush_valid = 0; agen_valid = 0;
    pred_valid = 0; br_valid = 0; retire_valid = 0;
  endtask

  task automatic alloc(input int ok_exp, input int ptr_exp, input string tag);
    @(negedge clk); alloc_valid = 1; #1;
    chk({tag, " alloc_ok"}, alloc_ok, ok_exp);
    if (ok_exp != 0) chk({tag, " alloc_ptr"}, alloc_ptr, ptr_exp);
    @(posedge clk); #1 idle();
  endtask

  task automatic branch(input int d, input int prim, input int hit_e, input int ptr_e,
                        input int use_e, input int pred_e, input string tag);
    @(negedge clk); br_valid = 1; br_dist = DW'(d); br_primary = prim[0]; #1;
    chk({tag, " br_hit"}, br_hit, hit_e);
    if (hit_e != 0) chk({tag, " br_ptr"}, br_ptr, ptr_e);
    chk({tag, " br_use"}, br_use, use_e);
    chk({tag, " br_pred"}, br_pred, pred_e);
    @(posedge clk); #1 idle();
  endtask

  task automatic agen(input int p, input int a, input int lv_e, input string tag);
    @(negedge clk); agen_valid = 1; agen_ptr = PW'(p); agen_addr = AW'(a); #1;
    chk({tag, " lookup_valid"}, lookup_valid, lv_e);
    if (lv_e != 0) begin
      chk({tag, " lookup_addr"}, lookup_addr, a);
      chk({tag, " lookup_ptr"}, lookup_ptr, p);
    end
    @(posedge clk); #1 idle();
  endtask

  task automatic pred(input int p, input int t, input int ov_e, input string tag);
    @(negedge clk); pred_valid = 1; pred_ptr = PW'(p); pred_taken = t[0]; #1;
    chk({tag, " ovr_valid"}, ovr_valid, ov_e);
    if (ov_e != 0) begin
      chk({tag, " ovr_ptr"}, ovr_ptr, p);
      chk({tag, " ovr_taken"}, ovr_taken, t);
    end
    @(posedge clk); #1 idle();
  endtask

  task automatic retire(input int p, input int t, input int uv_e, input int a_e, input string tag);
    @(negedge clk); retire_valid = 1; retire_ptr = PW'(p); retire_taken = t[0]; #1;
    chk({tag, " upd_valid"}, upd_valid, uv_e);
    if (uv_e != 0) begin
      chk({tag, " upd_addr"}, upd_addr, a_e);
      chk({tag, " upd_taken"}, upd_taken, t);
    end
    @(posedge clk); #1 idle();
  endtask

  task automatic free_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); free_valid = 1;
      @(posedge clk); #1 idle();
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 alloc_ptr", alloc_ptr, 0);
    chk("R1 alloc_ok", alloc_ok, 1);
    chk("R1 tail_ckpt", tail_ckpt, 0);
    branch(0, 0, 0, 0, 0, 0, "R1 empty");
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) alloc(1, i, "R2 fill");
    alloc(0, 0, "R2 full");
    @(negedge clk); #1 chk("R2 tail after drop", tail_ckpt, DEPTH);
  endtask

  task automatic t_agen();
    agen(3, 'h123, 1, "R3 live");
  endtask

  task automatic t_dist();
    branch(0, 0, 1, 7, 0, 0, "R4 dist0");
    branch(7, 0, 1, 0, 0, 0, "R4 dist7");
  endtask

  task automatic t_subst();
    pred(5, 1, 0, "R5 write");
    branch(2, 0, 1, 5, 1, 1, "R5 ready");
  endtask

  task automatic t_override();
    branch(1, 0, 1, 6, 0, 0, "R6 wait6");
    pred(6, 1, 1, "R6 differs");
    branch(3, 1, 1, 4, 0, 0, "R6 wait4");
    pred(4, 1, 0, "R6 agrees");
  endtask

  task automatic t_retire();
    retire(3, 1, 1, 'h123, "R7 addr present");
    retire(2, 0, 0, 0, "R7 no addr");
  endtask

  task automatic t_free();
    agen(0, 'h055, 1, "R8 prep");
    free_n(3);
    branch(4, 0, 1, 3, 0, 0, "R8 oldest live");
    branch(5, 0, 0, 0, 0, 0, "R8 freed");
    retire(0, 1, 0, 0, "R8 freed retire");
    agen(1, 'h0aa, 0, "R8 freed agen");
    alloc(1, 0, "R8 wrap");
    branch(0, 0, 1, 0, 0, 0, "R8 newest wrapped");
  endtask

  task automatic t_flush();
    logic [PW:0] ck;
    @(negedge clk); #1 ck = tail_ckpt;
    chk("R9 ckpt", ck, 9);
    alloc(1, 1, "R9 spec1");
    alloc(1, 2, "R9 spec2");
    @(negedge clk); flush_valid = 1; flush_tail = ck;
    @(posedge clk); #1 idle();
    @(negedge clk); #1;
    chk("R9 tail restored", tail_ckpt, 9);
    chk("R9 next ptr", alloc_ptr, 1);
    agen(2, 'h0f0, 0, "R9 dead slot");
    branch(0, 0, 1, 0, 0, 0, "R9 newest");
    free_n(6);
    branch(0, 0, 0, 0, 0, 0, "R8 drained");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_fill();
    t_agen();
    t_dist();
    t_subst();
    t_override();
    t_retire();
    t_free();
    t_flush();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule